// File: doc/BRIEF.md
# Two-Lane PAM4 Decision Feedback Equalizer with Split Feedback

This block is a cycle-level digital model of a four-tap decision feedback equalizer for four-level amplitude modulation. Every clock it accepts two signed samples, one for an even lane and one for an odd lane. Each lane subtracts two weighted earlier decisions from its sample. It then compares the result against an upper, a middle and a lower threshold and emits a 2-bit Gray code.

Feedback is split between the lanes rather than fully crossed. The even summer receives the odd lane's decisions: the most recent one weighted by the first tap, and the one before it, taken from one extra delay register, weighted by the third tap. The odd summer receives the even lane's decisions in the same way, weighted by the second and fourth taps. Tap weights and the outer threshold magnitude come from static configuration ports.

Top module: `pam4_hi_dfe`

## Requirements
- R1: A synchronous active-high reset sets both symbol outputs to 2'b01 (level -1/3), clears `out_valid`, and loads every stored past decision with level -1/3.
- R2: `out_valid` follows `in_valid` with one cycle of latency, and the symbols for a sample pair appear in that same cycle.
- R3: While `in_valid` is low, the symbol outputs and the stored decisions do not change, whatever the sample, weight and threshold inputs do.
- R4: With equalized value y and threshold magnitude T, a lane outputs 2'b10 when y >= T, 2'b11 when 0 <= y < T, 2'b01 when -T <= y < 0, and 2'b00 when y < -T. These codes stand for the levels +1, +1/3, -1/3 and -1.
- R5: A value exactly equal to a threshold (T, 0 or -T) is decided as the level just above that threshold.
- R6: The even lane subtracts tap-1 weight × the odd lane's most recent decision level. Decision levels are the integers +3, +1, -1 and -3 for codes 10, 11, 01 and 00.
- R7: The even lane subtracts tap-3 weight × the odd lane's decision from one valid pair earlier than the one used by tap 1.
- R8: The odd lane subtracts tap-2 weight × the even lane's most recent decision level, plus tap-4 weight × the even decision from one valid pair before that.
- R9: Each feedback term is weight × level divided by 3, truncated toward zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample pair on `x_even`/`x_odd` is valid |
| x_even | input | 10 | Even-lane signed sample |
| x_odd | input | 10 | Odd-lane signed sample |
| thr_outer | input | 10 | Unsigned magnitude of the upper/lower threshold |
| w_t1 | input | 8 | Signed tap-1 weight (odd decision into even summer) |
| w_t2 | input | 8 | Signed tap-2 weight (even decision into odd summer) |
| w_t3 | input | 8 | Signed tap-3 weight (delayed odd decision into even summer) |
| w_t4 | input | 8 | Signed tap-4 weight (delayed even decision into odd summer) |
| out_valid | output | 1 | Symbols on the outputs belong to a valid pair |
| sym_even | output | 2 | Even-lane Gray-coded decision |
| sym_odd | output | 2 | Odd-lane Gray-coded decision |

## Verification
Each even-lane decision depends on the direct odd-lane term and the delayed odd-lane term in the same cycle, and the odd lane mirrors this. So tap 1 and tap 3, or tap 2 and tap 4, both act on one summer at once. The bench sets both weights of a pair to non-zero values and drives sample sequences whose recent and older decisions differ. The scoreboard model computes both terms independently from the requirements, so a wrong delay depth or a wrong crossing changes the predicted code. Tie values at each threshold and a negative weight whose third is not a whole number separate truncation from floor division.

// File: rtl/pam4_hi_dfe_pkg.sv
package pam4_hi_dfe_pkg;

  typedef logic [1:0] sym_t;

  localparam sym_t SYM_P3 = 2'b10;
  localparam sym_t SYM_P1 = 2'b11;
  localparam sym_t SYM_M1 = 2'b01;
  localparam sym_t SYM_M3 = 2'b00;

  // Gray code to integer level in thirds of full scale
  function automatic logic signed [2:0] sym_level(input sym_t s);
    logic signed [2:0] l;
    case (s)
      SYM_P3:  l = 3'sd3;
      SYM_P1:  l = 3'sd1;
      SYM_M1:  l = -3'sd1;
      default: l = -3'sd3;
    endcase
    return l;
  endfunction

endpackage

// File: rtl/pam4_tap_product.sv
module pam4_tap_product
  import pam4_hi_dfe_pkg::*;
#(
  parameter int W_W = 8,
  localparam int P_W = W_W + 3
) (
  input  logic signed [W_W-1:0] weight,
  input  sym_t                  code,
  output logic signed [P_W-1:0] term
);

  localparam logic signed [P_W-1:0] DIV3 = P_W'(3);

  logic signed [P_W-1:0] w_ext;
  logic signed [P_W-1:0] l_ext;
  logic signed [P_W-1:0] full;
  logic signed [2:0]     lvl;

  always_comb begin
    lvl   = sym_level(code);
    w_ext = {{3{weight[W_W-1]}}, weight};
    l_ext = {{(P_W-3){lvl[2]}}, lvl};
    full  = w_ext * l_ext;
    term  = full / DIV3;   // signed division truncates toward zero
  end

endmodule

// File: rtl/pam4_lane_summer.sv
module pam4_lane_summer #(
  parameter int IN_W  = 10,
  parameter int P_W   = 11,
  parameter int SUM_W = 14,
  localparam int EXT_W = ((IN_W > P_W) ? IN_W : P_W) + 2
) (
  input  logic signed [IN_W-1:0]  x,
  input  logic signed [P_W-1:0]   t_near,
  input  logic signed [P_W-1:0]   t_far,
  output logic signed [SUM_W-1:0] y
);

  logic signed [EXT_W-1:0] full;

  always_comb begin
    full = {{(EXT_W-IN_W){x[IN_W-1]}}, x}
         - {{(EXT_W-P_W){t_near[P_W-1]}}, t_near}
         - {{(EXT_W-P_W){t_far[P_W-1]}}, t_far};
  end

  generate
    if (SUM_W > EXT_W) begin : g_wide
      // result range always fits: plain sign extension
      assign y = {{(SUM_W-EXT_W){full[EXT_W-1]}}, full};
    end else begin : g_clamp
      localparam logic signed [EXT_W-1:0] MAXV =
        {{(EXT_W-SUM_W+1){1'b0}}, {(SUM_W-1){1'b1}}};
      localparam logic signed [EXT_W-1:0] MINV =
        {{(EXT_W-SUM_W+1){1'b1}}, {(SUM_W-1){1'b0}}};
      always_comb begin
        if (full > MAXV)      y = MAXV[SUM_W-1:0];
        else if (full < MINV) y = MINV[SUM_W-1:0];
        else                  y = full[SUM_W-1:0];
      end
    end
  endgenerate

endmodule

// File: rtl/pam4_slicer.sv
module pam4_slicer
  import pam4_hi_dfe_pkg::*;
#(
  parameter int SUM_W = 14,
  parameter int THR_W = 10
) (
  input  logic signed [SUM_W-1:0] y,
  input  logic [THR_W-1:0]        thr,
  output sym_t                    code
);

  logic signed [SUM_W-1:0] t_hi;
  logic signed [SUM_W-1:0] t_lo;

  always_comb begin
    t_hi = {{(SUM_W-THR_W){1'b0}}, thr};
    t_lo = -t_hi;
    if (y >= t_hi)           code = SYM_P3;
    else if (y >= 0)         code = SYM_P1;
    else if (y >= t_lo)      code = SYM_M1;
    else                     code = SYM_M3;
  end

endmodule

// File: rtl/pam4_hi_dfe.sv
module pam4_hi_dfe
  import pam4_hi_dfe_pkg::*;
#(
  parameter int IN_W  = 10,
  parameter int W_W   = 8,
  parameter int SUM_W = 14,
  parameter int THR_W = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  x_even,
  input  logic signed [IN_W-1:0]  x_odd,
  input  logic [THR_W-1:0]        thr_outer,
  input  logic signed [W_W-1:0]   w_t1,
  input  logic signed [W_W-1:0]   w_t2,
  input  logic signed [W_W-1:0]   w_t3,
  input  logic signed [W_W-1:0]   w_t4,
  output logic                    out_valid,
  output logic [1:0]              sym_even,
  output logic [1:0]              sym_odd
);

  localparam int LANES = 2;
  localparam int P_W   = W_W + 3;

  // index 0 = even lane, 1 = odd lane
  sym_t                  dec_now  [LANES];
  sym_t                  dec_d1   [LANES];
  sym_t                  dec_d2   [LANES];
  logic signed [IN_W-1:0] x_ln    [LANES];
  logic signed [W_W-1:0]  w_near  [LANES];
  logic signed [W_W-1:0]  w_far   [LANES];

  assign x_ln[0]   = x_even;
  assign x_ln[1]   = x_odd;
  assign w_near[0] = w_t1;
  assign w_far[0]  = w_t3;
  assign w_near[1] = w_t2;
  assign w_far[1]  = w_t4;

  generate
    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      localparam int SRC = LANES - 1 - ln;  // feedback comes from the other lane

      logic signed [P_W-1:0]   t_near;
      logic signed [P_W-1:0]   t_far;
      logic signed [SUM_W-1:0] y_eq;

      pam4_tap_product #(.W_W(W_W)) u_near (
        .weight (w_near[ln]),
        .code   (dec_d1[SRC]),
        .term   (t_near)
      );

      pam4_tap_product #(.W_W(W_W)) u_far (
        .weight (w_far[ln]),
        .code   (dec_d2[SRC]),
        .term   (t_far)
      );

      pam4_lane_summer #(.IN_W(IN_W), .P_W(P_W), .SUM_W(SUM_W)) u_sum (
        .x      (x_ln[ln]),
        .t_near (t_near),
        .t_far  (t_far),
        .y      (y_eq)
      );

      pam4_slicer #(.SUM_W(SUM_W), .THR_W(THR_W)) u_slc (
        .y    (y_eq),
        .thr  (thr_outer),
        .code (dec_now[ln])
      );

      always_ff @(posedge clk) begin
        if (rst) begin
          dec_d1[ln] <= SYM_M1;
          dec_d2[ln] <= SYM_M1;
        end else if (in_valid) begin
          dec_d2[ln] <= dec_d1[ln];
          dec_d1[ln] <= dec_now[ln];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end

  assign sym_even = dec_d1[0];
  assign sym_odd  = dec_d1[1];

endmodule

// File: rtl/pam4_hi_dfe_chk.sv
module pam4_hi_dfe_chk #(
  parameter int IN_W  = 10,
  parameter int W_W   = 8,
  parameter int THR_W = 10
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   in_valid,
  input logic signed [IN_W-1:0] x_even,
  input logic [THR_W-1:0]       thr_outer,
  input logic signed [W_W-1:0]  w_t1,
  input logic signed [W_W-1:0]  w_t3,
  input logic                   out_valid,
  input logic [1:0]             sym_even,
  input logic [1:0]             sym_odd
);

  localparam int CW = ((IN_W > THR_W) ? IN_W : THR_W) + 2;

  logic signed [CW-1:0] xe_c;
  logic signed [CW-1:0] tp_c;
  logic                 no_fb_e;

  always_comb begin
    xe_c    = {{(CW-IN_W){x_even[IN_W-1]}}, x_even};
    tp_c    = {{(CW-THR_W){1'b0}}, thr_outer};
    no_fb_e = (w_t1 == '0) && (w_t3 == '0);
  end

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!out_valid && sym_even == 2'b01 && sym_odd == 2'b01));

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r2_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(sym_even) && $stable(sym_odd)));

  a_r4_top_level: assert property (@(posedge clk) disable iff (rst)
    (in_valid && no_fb_e && xe_c > tp_c) |=> sym_even == 2'b10);

  a_r4_bottom_level: assert property (@(posedge clk) disable iff (rst)
    (in_valid && no_fb_e && xe_c < -tp_c) |=> sym_even == 2'b00);

  a_r5_tie_upper: assert property (@(posedge clk) disable iff (rst)
    (in_valid && no_fb_e && xe_c == tp_c) |=> sym_even == 2'b10);

  a_r5_tie_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && no_fb_e && xe_c == '0 && thr_outer != '0) |=> sym_even == 2'b11);

endmodule

bind pam4_hi_dfe pam4_hi_dfe_chk #(.IN_W(IN_W), .W_W(W_W), .THR_W(THR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .x_even    (x_even),
  .thr_outer (thr_outer),
  .w_t1      (w_t1),
  .w_t3      (w_t3),
  .out_valid (out_valid),
  .sym_even  (sym_even),
  .sym_odd   (sym_odd)
);

// File: tb/tb_pam4_hi_dfe.sv
module tb_pam4_hi_dfe;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic signed [9:0] x_even = '0;
  logic signed [9:0] x_odd = '0;
  logic [9:0]        thr_outer = 10'd300;
  logic signed [7:0] w_t1 = '0;
  logic signed [7:0] w_t2 = '0;
  logic signed [7:0] w_t3 = '0;
  logic signed [7:0] w_t4 = '0;
  logic              out_valid;
  logic [1:0]        sym_even;
  logic [1:0]        sym_odd;

  int n_checks = 0;
  int n_errors = 0;

  // model history, in levels (+3,+1,-1,-3)
  int he1 = -1, he2 = -1, ho1 = -1, ho2 = -1;

  logic [3:0] q_exp[$];
  string      q_tag[$];

  always #10 clk = ~clk;

  pam4_hi_dfe dut (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .x_even(x_even), .x_odd(x_odd), .thr_outer(thr_outer),
    .w_t1(w_t1), .w_t2(w_t2), .w_t3(w_t3), .w_t4(w_t4),
    .out_valid(out_valid), .sym_even(sym_even), .sym_odd(sym_odd)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int lvl_of(input logic [1:0] c);
    case (c)
      2'b10: return 3;
      2'b11: return 1;
      2'b01: return -1;
      default: return -3;
    endcase
  endfunction

  function automatic logic [1:0] slice(input int y, input int t);
    if (y >= t) return 2'b10;
    if (y >= 0) return 2'b11;
    if (y >= -t) return 2'b01;
    return 2'b00;
  endfunction

  function automatic int clamp14(input int v);
    if (v > 8191) return 8191;
    if (v < -8192) return -8192;
    return v;
  endfunction

  // driver: applies one pair, predicts and queues the result
  task automatic drive(input int xe, input int xo, input string tag);
    int ye, yo;
    logic [1:0] ce, co;
    @(negedge clk);
    x_even   = 10'(xe);
    x_odd    = 10'(xo);
    in_valid = 1'b1;
    ye = clamp14(xe - (int'(w_t1) * ho1) / 3 - (int'(w_t3) * ho2) / 3);
    yo = clamp14(xo - (int'(w_t2) * he1) / 3 - (int'(w_t4) * he2) / 3);
    ce = slice(ye, int'(thr_outer));
    co = slice(yo, int'(thr_outer));
    he2 = he1; he1 = lvl_of(ce);
    ho2 = ho1; ho1 = lvl_of(co);
    q_exp.push_back({ce, co});
    q_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic set_w(input int a, input int b, input int c, input int d);
    @(negedge clk);
    in_valid = 1'b0;
    w_t1 = 8'(a); w_t2 = 8'(b); w_t3 = 8'(c); w_t4 = 8'(d);
  endtask

  // monitor: compares design output against the queue
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && out_valid) begin
        if (q_exp.size() == 0) begin
          check(1'b0, "R2 unexpected out_valid", 1, 0);
        end else begin
          logic [3:0] e;
          string t;
          e = q_exp.pop_front();
          t = q_tag.pop_front();
          check(sym_even == e[3:2], {t, " even"}, int'(sym_even), int'(e[3:2]));
          check(sym_odd == e[1:0], {t, " odd"}, int'(sym_odd), int'(e[1:0]));
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    check(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    logic [1:0] hold_e, hold_o;
    logic [15:0] lfsr;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    check(sym_even == 2'b01, "R1 sym_even", int'(sym_even), 1);
    check(sym_odd == 2'b01, "R1 sym_odd", int'(sym_odd), 1);
    @(negedge clk);
    rst = 1'b0;

    // R4: levels with no feedback
    drive(400, -400, "R4 outer");
    drive(100, -100, "R4 inner");
    drive(-100, 100, "R4 inner swap");
    drive(-400, 400, "R4 outer swap");

    // R5: ties at each threshold
    drive(300, 0, "R5 upper/zero");
    drive(-300, -301, "R5 lower/below");
    drive(0, 300, "R5 zero/upper");

    // R2: latency and drop of valid
    idle(1);
    check(out_valid == 1'b1, "R2 valid after last pair", int'(out_valid), 1);
    @(negedge clk);
    check(out_valid == 1'b0, "R2 valid low when idle", int'(out_valid), 0);

    // R3: changing inputs while idle leaves outputs untouched
    hold_e = sym_even;
    hold_o = sym_odd;
    x_even = -500; x_odd = 500; thr_outer = 10'd5;
    w_t1 = 8'sd100; w_t2 = -8'sd100;
    repeat (3) @(negedge clk);
    check(sym_even == hold_e, "R3 even held", int'(sym_even), int'(hold_e));
    check(sym_odd == hold_o, "R3 odd held", int'(sym_odd), int'(hold_o));
    thr_outer = 10'd300;

    // R6: tap 1 only
    set_w(90, 0, 0, 0);
    drive(0, 400, "R6 prime");
    drive(50, 0, "R6 direct odd->even");
    drive(-50, -400, "R6 second");
    drive(50, 0, "R6 negative feedback");

    // R7: tap 3 only, delayed odd decision
    set_w(0, 0, 120, 0);
    drive(0, 400, "R7 prime a");
    drive(0, -400, "R7 prime b");
    drive(60, 0, "R7 delayed odd->even");
    drive(-60, 0, "R7 delayed again");

    // R8: taps 2 and 4 into odd lane
    set_w(0, 100, 0, -80);
    drive(400, 0, "R8 prime a");
    drive(-400, 0, "R8 prime b");
    drive(0, 70, "R8 both terms");
    drive(0, -70, "R8 both terms b");

    // R9: truncation toward zero with a negative weight
    set_w(-100, 0, 0, 0);
    drive(0, 100, "R9 prime");
    drive(-34, 100, "R9 trunc -34");
    drive(-33, 100, "R9 trunc -33");
    set_w(100, 0, 0, 0);
    drive(0, 100, "R9 prime pos");
    drive(32, 100, "R9 trunc 32");
    drive(33, 100, "R9 trunc 33");

    // mixed: all taps active at once, pseudo-random samples
    set_w(70, -55, 35, 25);
    lfsr = 16'hACE1;
    for (int i = 0; i < 40; i++) begin
      int a, b;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = int'($signed(lfsr[9:0]));
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      b = int'($signed(lfsr[9:0]));
      drive(a, b, "R8 mixed taps");
    end

    idle(3);
    check(q_exp.size() == 0, "R2 queue drained", q_exp.size(), 0);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule